// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the 32-entry, 16-bit register space that a copper Ethernet PHY presents over its serial management interface. A serial front end, not part of this block, decodes management frames and presents one register access at a time on a simple synchronous port. The port carries a 5-bit register address, a write strobe with write data, and a read strobe. Read data is combinational from the address. The read strobe only marks a qualified read, so that read side effects happen once per access.

Each address has its own access policy:
- A few registers store what is written.
- Some return fixed or configured values.
- Several acknowledge their address but read as zero and discard writes.
- Unmapped addresses behave the same way as those zero registers.

A level input from the line side reports whether the link is up. The block turns its edges into updates of the status registers. The link bit in the basic status register is latched low. Writing the reset bit in the control register performs a selective soft reset and sends a one-cycle pulse toward the MAC.

Top module: `mgmt_reg_bank`

## Requirements
- R1: After hard reset the block reads as follows.
  - Address 0 (control) reads 0x1140: speed MSB bit 6, duplex bit 8 and auto-negotiation enable bit 12 are set.
  - Address 1 (status) reads 0x7949.
  - Address 4 (advertisement) reads 0x01E1.
  - Address 5 (partner ability) reads 0x01E0.
  - Address 9 (gigabit control) reads 0x1E00.
  - Address 16 (vendor control) reads 0x0068.
  - Address 17 (vendor status) reads 0x0000.
- R2: Three addresses return fixed or configured values. Address 2 always reads 0x0141, address 3 always reads the `extId` input, and address 10 always reads 0x3C00.
- R3: Addresses 4 and 16 store any written value. Address 0 stores the written value when bit 15 of the write data is 0.
- R4: Writes to addresses 1, 2, 3, 5, 9, 10 and 17 leave their read values unchanged.
- R5: Addresses 6, 7, 8, 11 to 15, 18 to 31 read 0, both before and after any write to them, and a write to them changes no other register.
- R6: A write to address 0 with bit 15 set does not store the written value. Instead it performs a soft reset:
  - control becomes its old value ANDed with 0x3140, so only bits 6, 8, 12 and 13 are kept;
  - status becomes 0x7949;
  - vendor status is ANDed with 0xE001;
  - advertisement and vendor control are untouched.
- R7: On the clock edge that takes a soft-reset write, `linkResetPulse` rises. It stays high for exactly one cycle.
- R8: On the clock edge after `linkUp` rises, vendor status is ORed with the link group mask 0xEC00, which includes link bit 10. In the same update, status bit 5 (negotiation complete) is set while status bit 2 (link) stays as it was.
- R9: A status read returns the currently latched status. On the edge of the qualified read (`rdEn` high with address 1), status bit 2 is reloaded from vendor status bit 10.
- R10: On the clock edge after `linkUp` falls, three things are cleared:
  - the link group bits (mask 0xEC00) in vendor status;
  - status bit 2;
  - status bit 5.
  A link fall takes priority over a simultaneous status-read refresh, and a soft reset takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hard reset |
| linkUp | input | 1 | Live link level from the line side |
| extId | input | 16 | Configured extended identifier value read at address 3 |
| regAddr | input | 5 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Qualified read strobe; triggers read side effects |
| rdData | output | 16 | Combinational read data for `regAddr` |
| linkResetPulse | output | 1 | One-cycle pulse after a soft reset |

## Verification
The bench builds the block with its default parameters: 16-bit registers, a 5-bit address and link group mask 0xEC00. It sets `extId` to 0xBEEF.

With only 32 addresses, every address is read after reset and again after a write to every address except 0. This covers each access policy, including the unmapped holes. Directed sequences then run the interactions among link edges, latched-low refresh and soft reset. Expected values come from a shadow model built from the requirements.

// File: rtl/mgmt_reg_pkg.sv
package mgmt_reg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTL     = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'd1;
  localparam logic [ADDR_W-1:0] A_ID      = 5'd2;
  localparam logic [ADDR_W-1:0] A_EXTID   = 5'd3;
  localparam logic [ADDR_W-1:0] A_ADV     = 5'd4;
  localparam logic [ADDR_W-1:0] A_PARTNER = 5'd5;
  localparam logic [ADDR_W-1:0] A_GCTL    = 5'd9;
  localparam logic [ADDR_W-1:0] A_GSTAT   = 5'd10;
  localparam logic [ADDR_W-1:0] A_SCTL    = 5'd16;
  localparam logic [ADDR_W-1:0] A_SSTAT   = 5'd17;

  localparam int BIT_RESET   = 15;
  localparam int BIT_LINK    = 2;
  localparam int BIT_NEGDONE = 5;
  localparam int BIT_SLINK   = 10;

  localparam logic [DATA_W-1:0] RST_CTL     = 16'h1140;
  localparam logic [DATA_W-1:0] RST_STAT    = 16'h7949;
  localparam logic [DATA_W-1:0] RST_ADV     = 16'h01E1;
  localparam logic [DATA_W-1:0] VAL_PARTNER = 16'h01E0;
  localparam logic [DATA_W-1:0] VAL_ID      = 16'h0141;
  localparam logic [DATA_W-1:0] VAL_GCTL    = 16'h1E00;
  localparam logic [DATA_W-1:0] VAL_GSTAT   = 16'h3C00;
  localparam logic [DATA_W-1:0] RST_SCTL    = 16'h0068;
  localparam logic [DATA_W-1:0] SOFT_KEEP   = 16'h3140;
  localparam logic [DATA_W-1:0] SSTAT_KEEP  = 16'hE001;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_CTL, SEL_STAT, SEL_ID, SEL_EXTID, SEL_ADV,
    SEL_PARTNER, SEL_GCTL, SEL_GSTAT, SEL_SCTL, SEL_SSTAT
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrAdv;
    logic   wrSctl;
    logic   softRst;
    logic   statRead;
    logic   linkRise;
    logic   linkFall;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/mgmt_reg_ctrl.sv
module mgmt_reg_ctrl
  import mgmt_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              wrResetBit,
  input  logic              rdEn,
  output strobes_t          st
);
  logic linkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) linkPrev <= 1'b0;
    else       linkPrev <= linkUp;
  end

  always_comb begin
    st          = '0;
    st.wrCtl    = wrEn && (regAddr == A_CTL) && !wrResetBit;
    st.softRst  = wrEn && (regAddr == A_CTL) && wrResetBit;
    st.wrAdv    = wrEn && (regAddr == A_ADV);
    st.wrSctl   = wrEn && (regAddr == A_SCTL);
    st.statRead = rdEn && (regAddr == A_STAT);
    st.linkRise = linkUp && !linkPrev;
    st.linkFall = !linkUp && linkPrev;
    case (regAddr)
      A_CTL:     st.rdSel = SEL_CTL;
      A_STAT:    st.rdSel = SEL_STAT;
      A_ID:      st.rdSel = SEL_ID;
      A_EXTID:   st.rdSel = SEL_EXTID;
      A_ADV:     st.rdSel = SEL_ADV;
      A_PARTNER: st.rdSel = SEL_PARTNER;
      A_GCTL:    st.rdSel = SEL_GCTL;
      A_GSTAT:   st.rdSel = SEL_GSTAT;
      A_SCTL:    st.rdSel = SEL_SCTL;
      A_SSTAT:   st.rdSel = SEL_SSTAT;
      default:   st.rdSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/mgmt_reg_data.sv
module mgmt_reg_data
  import mgmt_reg_pkg::*;
#(
  parameter logic [DATA_W-1:0] LINK_MASK = 16'hEC00
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extId,
  output logic [DATA_W-1:0] rdData,
  output logic              linkResetPulse
);
  logic [DATA_W-1:0] ctlQ, statQ, advQ, sctlQ, sstatQ;
  logic [DATA_W-1:0] statNext, sstatNext;
  logic              pulseQ;

  // Vendor status: link edges first, then the soft-reset mask.
  always_comb begin
    sstatNext = sstatQ;
    if (st.linkRise) sstatNext = sstatNext | LINK_MASK;
    if (st.linkFall) sstatNext = sstatNext & ~LINK_MASK;
    if (st.softRst)  sstatNext = sstatNext & SSTAT_KEEP;
  end

  // Status priority, lowest to highest: rise, read refresh, fall, soft reset.
  always_comb begin
    statNext = statQ;
    if (st.linkRise) statNext[BIT_NEGDONE] = 1'b1;
    if (st.statRead) statNext[BIT_LINK] = sstatQ[BIT_SLINK];
    if (st.linkFall) begin
      statNext[BIT_LINK]    = 1'b0;
      statNext[BIT_NEGDONE] = 1'b0;
    end
    if (st.softRst) statNext = RST_STAT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ   <= RST_CTL;
      statQ  <= RST_STAT;
      advQ   <= RST_ADV;
      sctlQ  <= RST_SCTL;
      sstatQ <= '0;
      pulseQ <= 1'b0;
    end else begin
      if (st.wrCtl)   ctlQ <= wrData;
      if (st.softRst) ctlQ <= ctlQ & SOFT_KEEP;
      if (st.wrAdv)   advQ <= wrData;
      if (st.wrSctl)  sctlQ <= wrData;
      statQ  <= statNext;
      sstatQ <= sstatNext;
      pulseQ <= st.softRst;
    end
  end

  always_comb begin
    case (st.rdSel)
      SEL_CTL:     rdData = ctlQ;
      SEL_STAT:    rdData = statQ;
      SEL_ID:      rdData = VAL_ID;
      SEL_EXTID:   rdData = extId;
      SEL_ADV:     rdData = advQ;
      SEL_PARTNER: rdData = VAL_PARTNER;
      SEL_GCTL:    rdData = VAL_GCTL;
      SEL_GSTAT:   rdData = VAL_GSTAT;
      SEL_SCTL:    rdData = sctlQ;
      SEL_SSTAT:   rdData = sstatQ;
      default:     rdData = '0;
    endcase
  end

  assign linkResetPulse = pulseQ;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mgmt_reg_pkg::*;
#(
  parameter logic [DATA_W-1:0] LINK_MASK = 16'hEC00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic [DATA_W-1:0] extId,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              linkResetPulse
);
  strobes_t st;

  mgmt_reg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .regAddr(regAddr),
    .wrEn(wrEn), .wrResetBit(wrData[BIT_RESET]), .rdEn(rdEn), .st(st)
  );

  mgmt_reg_data #(.LINK_MASK(LINK_MASK)) uData (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .extId(extId),
    .rdData(rdData), .linkResetPulse(linkResetPulse)
  );
endmodule

// File: rtl/mgmt_reg_bank_chk.sv
module mgmt_reg_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        linkUp,
  input logic [4:0]  regAddr,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        rdEn,
  input logic [15:0] rdData,
  input logic        linkResetPulse
);
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 5'd2 |-> rdData == 16'h0141); // R2
  AST_GSTAT_CONST: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 5'd10 |-> rdData == 16'h3C00); // R2
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr inside {[5'd6:5'd8], [5'd11:5'd15], [5'd18:5'd31]}) |-> rdData == 16'h0000); // R5
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 5'd0 && wrData[15]) |=> linkResetPulse); // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    linkResetPulse |-> $past(wrEn && regAddr == 5'd0 && wrData[15])); // R7
  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'd1 && $past(regAddr == 5'd1) && !$past(rdEn) && !$past(wrEn))
      |-> !$rose(rdData[2])); // R9
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(linkUp) && $past(rstN) && !(wrEn && regAddr == 5'd0 && wrData[15]))
      |=> (regAddr != 5'd1 || (!rdData[2] && !rdData[5]))); // R10
endmodule

bind mgmt_reg_bank mgmt_reg_bank_chk uChk (.*);

// File: tb/mgmt_reg_bank_test.sv
module mgmt_reg_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b0;
  logic [15:0] extId = 16'hBEEF;
  logic [4:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        linkResetPulse;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // shadow model derived from the requirements
  logic [15:0] mCtl, mStat, mAdv, mSctl, mSstat;

  mgmt_reg_bank uut (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .extId(extId), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .linkResetPulse(linkResetPulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [15:0] expVal(input logic [4:0] a);
    case (a)
      5'd0:  return mCtl;
      5'd1:  return mStat;
      5'd2:  return 16'h0141;
      5'd3:  return extId;
      5'd4:  return mAdv;
      5'd5:  return 16'h01E0;
      5'd9:  return 16'h1E00;
      5'd10: return 16'h3C00;
      5'd16: return mSctl;
      5'd17: return mSstat;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    case (a)
      5'd2, 5'd3, 5'd10: return "R2";
      5'd0, 5'd1, 5'd4, 5'd5, 5'd9, 5'd16, 5'd17: return "R1";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readAt(input logic [4:0] a, input string tag);
    @(negedge clk);
    regAddr = a; rdEn = 1'b0; wrEn = 1'b0;
    #1 check(tag, rdData, expVal(a));
  endtask

  // qualified status read: returns latched value, then refreshes bit 2
  task automatic readStatus(input string tag);
    @(negedge clk);
    regAddr = 5'd1; rdEn = 1'b1;
    #1 check(tag, rdData, mStat);
    @(negedge clk);
    rdEn = 1'b0;
    mStat[2] = mSstat[10];
  endtask

  task automatic writeAt(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setLink(input logic v);
    @(negedge clk);
    linkUp = v;
    @(negedge clk);
    if (v) begin
      mSstat = mSstat | 16'hEC00;
      mStat[5] = 1'b1;
    end else begin
      mSstat = mSstat & ~16'hEC00;
      mStat[2] = 1'b0;
      mStat[5] = 1'b0;
    end
  endtask

  initial begin
    mCtl = 16'h1140; mStat = 16'h7949; mAdv = 16'h01E1;
    mSctl = 16'h0068; mSstat = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R5: whole address space after reset
    for (int a = 0; a < 32; a++) readAt(5'(a), tagFor(5'(a)));
    check("R7 idle", {15'd0, linkResetPulse}, 16'd0);

    // R3 R4 R5: write every address except control, then sweep
    for (int a = 1; a < 32; a++) begin
      logic [15:0] p;
      p = 16'h5A00 ^ {a[7:0], 3'b101, a[4:0]};
      writeAt(5'(a), p);
      if (a == 4)  mAdv = p;
      if (a == 16) mSctl = p;
    end
    for (int a = 0; a < 32; a++) begin
      string t;
      t = (a == 4 || a == 16) ? "R3" :
          (a inside {1, 2, 3, 5, 9, 10, 17}) ? "R4" :
          (a == 0) ? "R1" : "R5";
      readAt(5'(a), t);
    end

    // R3: control stores when bit 15 is clear
    writeAt(5'd0, 16'h2100); mCtl = 16'h2100;
    readAt(5'd0, "R3");
    writeAt(5'd0, 16'h7FFF); mCtl = 16'h7FFF;
    readAt(5'd0, "R3");
    check("R7 no pulse on plain write", {15'd0, linkResetPulse}, 16'd0);

    // R8: rise sets negotiation complete, link bit stays low
    setLink(1'b1);
    readAt(5'd17, "R8");
    readAt(5'd1, "R8");
    readStatus("R9 latched low");
    readStatus("R9 refreshed");

    // R6 R7: soft reset
    @(negedge clk);
    regAddr = 5'd0; wrData = 16'h8000; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 pulse high", {15'd0, linkResetPulse}, 16'd1);
    mCtl = mCtl & 16'h3140; mStat = 16'h7949; mSstat = mSstat & 16'hE001;
    @(negedge clk);
    check("R7 pulse one cycle", {15'd0, linkResetPulse}, 16'd0);
    readAt(5'd0, "R6");
    readAt(5'd1, "R6");
    readAt(5'd17, "R6");
    readAt(5'd4, "R6");
    readAt(5'd16, "R6");
    readStatus("R9 after soft reset");
    readAt(5'd1, "R9");

    // R10: fall clears link group and status bits
    setLink(1'b0);
    readAt(5'd17, "R10");
    readAt(5'd1, "R10");

    // R8 R9 R10: rise, latch high by read, then fall clears it
    setLink(1'b1);
    readStatus("R9 returns latched");
    readAt(5'd1, "R9");
    setLink(1'b0);
    readAt(5'd1, "R10");
    readAt(5'd17, "R10");

    // R10: fall coinciding with a status read leaves bit 2 clear
    setLink(1'b1);
    readStatus("R9");
    @(negedge clk);
    linkUp = 1'b0; regAddr = 5'd1; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    mSstat = mSstat & ~16'hEC00; mStat[2] = 1'b0; mStat[5] = 1'b0;
    readAt(5'd1, "R10 over read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule